// File: doc/BRIEF.md
# Outbound Address Translation Windows

This block holds a small bank of programmable outbound windows that map a region of the 64-bit local bus address space onto the PCI address space. Software programs each window through a 32-bit register port: a 64-bit local base and a 64-bit PCI base, each written as two 32-bit halves, and a size word. Bit 0 of the size word enables the window. The remaining bits are a mask whose two's complement gives the window length.

A combinational lookup port takes a local address. It reports whether an enabled window covers the address, which window it is, and the translated PCI address. The translated address is the window's PCI base plus the offset of the address from the local base. One further window has only a size word. Software can store and read back that word, but the word creates no mapping.

Top module: `obwin_xlate`

## Requirements
- R1: After reset every register reads zero and no lookup hits.
- R2: Register offsets are: window 0 local base low 0x68, local base high 0x6C, size 0x70, PCI base low 0x74, PCI base high 0x78. Window 1 uses the same layout at 0x7C, 0x80, 0x84, 0x88 and 0x8C. The size-only word is at 0x90. Each of these registers reads back the value last written to it.
- R3: A write to the low or high half of a 64-bit base changes only that half and keeps the other half.
- R4: A window whose size word has bit 0 clear never hits.
- R5: The window length is the 32-bit two's complement of the size word with bit 0 cleared. An address hits when it is at or above the local base and its offset from the base is below the length. On a hit, lk_pci_addr equals the PCI base plus that offset.
- R6: If the length computes to zero, the length is 0xFFFFFFFF. An offset of 0xFFFFFFFE then hits and an offset of 0xFFFFFFFF misses.
- R7: When several windows hit, the lowest-numbered window wins, and lk_idx reports its number.
- R8: The size-only word never produces a hit, whatever value it holds.
- R9: Reads of any other offset return zero. Writes to any other offset change no register.
- R10: A register write takes effect at the clock edge that captures it. A lookup in the same cycle still uses the old settings. On a miss, lk_idx and lk_pci_addr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| lk_addr | input | 64 | Local address to look up |
| lk_hit | output | 1 | An enabled window covers lk_addr |
| lk_idx | output | 2 | Number of the winning window |
| lk_pci_addr | output | 64 | Translated PCI address |

## Verification
A register write and a lookup can fall in the same cycle, and the write may change the very window being looked up. The bench drives a size write that enables window 0 while it holds a lookup address inside that window. It samples the lookup port before the capturing edge and expects a miss. It then samples again after the edge and expects a hit with the translated address.

// File: rtl/obwin_pkg.sv
package obwin_pkg;

  localparam int REG_AW   = 8;
  localparam int REG_DW   = 32;
  localparam int LADDR_W  = 64;

  localparam int FIRST_OFF = 'h68;
  localparam int STRIDE    = 'h14;
  localparam int SPARE_OFF = 'h90;

  localparam int F_LLO  = 0;
  localparam int F_LHI  = 1;
  localparam int F_SIZE = 2;
  localparam int F_PLO  = 3;
  localparam int F_PHI  = 4;
  localparam int NFIELD = 5;

  function automatic logic [REG_AW-1:0] reg_off(input int win, input int fld);
    return REG_AW'(FIRST_OFF + STRIDE * win + 4 * fld);
  endfunction

  function automatic logic [31:0] win_span(input logic [31:0] size_word);
    logic [31:0] s;
    s = (~(size_word & 32'hFFFF_FFFE)) + 32'd1;
    if (s == 32'd0) s = 32'hFFFF_FFFF;
    return s;
  endfunction

  function automatic logic win_covers(input logic [63:0] addr,
                                      input logic [63:0] base,
                                      input logic [31:0] span);
    logic [63:0] off;
    off = addr - base;
    return (addr >= base) && (off < {32'd0, span});
  endfunction

  function automatic logic [63:0] win_move(input logic [63:0] addr,
                                           input logic [63:0] lbase,
                                           input logic [63:0] pbase);
    return pbase + (addr - lbase);
  endfunction

endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
  import obwin_pkg::*;
#(
  parameter int NW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic [63:0]       lbase [NW],
  output logic [63:0]       pbase [NW],
  output logic [31:0]       ctl   [NW],
  output logic [31:0]       spare_ctl
);

  for (genvar k = 0; k < NW; k++) begin : g_win
    logic wr_llo, wr_lhi, wr_size, wr_plo, wr_phi;
    assign wr_llo  = reg_wr && (reg_addr == reg_off(k, F_LLO));
    assign wr_lhi  = reg_wr && (reg_addr == reg_off(k, F_LHI));
    assign wr_size = reg_wr && (reg_addr == reg_off(k, F_SIZE));
    assign wr_plo  = reg_wr && (reg_addr == reg_off(k, F_PLO));
    assign wr_phi  = reg_wr && (reg_addr == reg_off(k, F_PHI));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lbase[k] <= '0;
        pbase[k] <= '0;
        ctl[k]   <= '0;
      end else begin
        if (wr_llo)  lbase[k][31:0]  <= reg_wdata;
        if (wr_lhi)  lbase[k][63:32] <= reg_wdata;
        if (wr_size) ctl[k]          <= reg_wdata;
        if (wr_plo)  pbase[k][31:0]  <= reg_wdata;
        if (wr_phi)  pbase[k][63:32] <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      spare_ctl <= '0;
    else if (reg_wr && reg_addr == REG_AW'(SPARE_OFF))
      spare_ctl <= reg_wdata;
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NW; k++) begin
      if (reg_addr == reg_off(k, F_LLO))  reg_rdata = lbase[k][31:0];
      if (reg_addr == reg_off(k, F_LHI))  reg_rdata = lbase[k][63:32];
      if (reg_addr == reg_off(k, F_SIZE)) reg_rdata = ctl[k];
      if (reg_addr == reg_off(k, F_PLO))  reg_rdata = pbase[k][31:0];
      if (reg_addr == reg_off(k, F_PHI))  reg_rdata = pbase[k][63:32];
    end
    if (reg_addr == REG_AW'(SPARE_OFF)) reg_rdata = spare_ctl;
  end

endmodule

// File: rtl/obwin_match.sv
module obwin_match
  import obwin_pkg::*;
(
  input  logic [63:0] lk_addr,
  input  logic [63:0] lbase,
  input  logic [63:0] pbase,
  input  logic [31:0] ctl,
  output logic        en,
  output logic        hit,
  output logic [63:0] xaddr
);

  logic [31:0] span;

  assign en    = ctl[0];
  assign span  = win_span(ctl);
  assign hit   = en && win_covers(lk_addr, lbase, span);
  assign xaddr = win_move(lk_addr, lbase, pbase);

endmodule

// File: rtl/obwin_prio.sv
module obwin_prio #(
  parameter int NW    = 2,
  parameter int IDX_W = 2
) (
  input  logic [NW-1:0]    hit_vec,
  input  logic [63:0]      xaddr [NW],
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [63:0]      lk_pci_addr
);

  always_comb begin
    lk_hit      = 1'b0;
    lk_idx      = '0;
    lk_pci_addr = '0;
    for (int k = NW - 1; k >= 0; k--) begin
      if (hit_vec[k]) begin
        lk_hit      = 1'b1;
        lk_idx      = IDX_W'(k);
        lk_pci_addr = xaddr[k];
      end
    end
  end

endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obwin_pkg::*;
#(
  parameter int NW    = 2,
  parameter int IDX_W = $clog2(NW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [63:0]       lk_addr,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [63:0]       lk_pci_addr
);

  logic [63:0]   lbase [NW];
  logic [63:0]   pbase [NW];
  logic [31:0]   ctl   [NW];
  logic [31:0]   spare_ctl;
  logic [NW-1:0] win_en;
  logic [NW-1:0] hit_vec;
  logic [63:0]   xaddr [NW];

  obwin_regs #(.NW(NW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .lbase     (lbase),
    .pbase     (pbase),
    .ctl       (ctl),
    .spare_ctl (spare_ctl)
  );

  for (genvar k = 0; k < NW; k++) begin : g_match
    obwin_match u_match (
      .lk_addr (lk_addr),
      .lbase   (lbase[k]),
      .pbase   (pbase[k]),
      .ctl     (ctl[k]),
      .en      (win_en[k]),
      .hit     (hit_vec[k]),
      .xaddr   (xaddr[k])
    );
  end

  obwin_prio #(.NW(NW), .IDX_W(IDX_W)) u_prio (
    .hit_vec     (hit_vec),
    .xaddr       (xaddr),
    .lk_hit      (lk_hit),
    .lk_idx      (lk_idx),
    .lk_pci_addr (lk_pci_addr)
  );

endmodule

// File: rtl/obwin_chk.sv
module obwin_chk
  import obwin_pkg::*;
#(
  parameter int NW    = 2,
  parameter int IDX_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_wdata,
  input logic              lk_hit,
  input logic [IDX_W-1:0]  lk_idx,
  input logic [63:0]       lk_pci_addr,
  input logic [NW-1:0]     win_en,
  input logic [NW-1:0]     hit_vec,
  input logic [63:0]       lbase [NW]
);

  logic [NW-1:0] below_mask;
  always_comb begin
    below_mask = '0;
    for (int k = 0; k < NW; k++)
      if (k < int'(lk_idx)) below_mask[k] = 1'b1;
  end

  // R4
  win_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~win_en) == '0);

  // R7
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((hit_vec & below_mask) == '0) && hit_vec[lk_idx]);

  // R8
  no_spare_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (int'(lk_idx) < NW));

  // R10
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_idx == '0) && (lk_pci_addr == '0));

  // R1
  all_off_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en == '0) |-> !lk_hit);

  // R10
  size_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == reg_off(0, F_SIZE)) |=> (win_en[0] == $past(reg_wdata[0])));

  // R3
  low_half_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == reg_off(0, F_LLO)) |=> $stable(lbase[0][63:32]));

endmodule

bind obwin_xlate obwin_chk #(.NW(NW), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .lk_hit      (lk_hit),
  .lk_idx      (lk_idx),
  .lk_pci_addr (lk_pci_addr),
  .win_en      (win_en),
  .hit_vec     (hit_vec),
  .lbase       (lbase)
);

// File: tb/obwin_xlate_test.sv
module obwin_xlate_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] lk_addr = '0;
  logic        lk_hit;
  logic [1:0]  lk_idx;
  logic [63:0] lk_pci_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  obwin_xlate uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pci_addr(lk_pci_addr)
  );

  // Window 0: local 0x1_0000_0000, 1 MiB, PCI 0x8000_0000.
  // Window 1: local 0x1_000F_8000, 64 KiB, PCI 0x2_0000_0000 (overlaps the top of window 0).
  localparam logic [63:0] V_ADDR [NV] = '{
    64'h1_0000_0000, 64'h1_000F_FFFF, 64'h1_000F_8000, 64'h1_0010_0000,
    64'h1_0010_7FFF, 64'h1_0010_8000, 64'h0_FFFF_FFFF, 64'h0
  };
  localparam logic V_HIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [1:0] V_IDX [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd0, 2'd0};
  localparam logic [63:0] V_PCI [NV] = '{
    64'h0_8000_0000, 64'h0_800F_FFFF, 64'h0_800F_8000, 64'h2_0000_8000,
    64'h2_0000_FFFF, 64'h0, 64'h0, 64'h0
  };

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk32(req, reg_rdata, exp);
  endtask

  task automatic lk_chk(input string req, input logic [63:0] a, input logic h,
                        input logic [1:0] i, input logic [63:0] p);
    lk_addr = a;
    #1;
    checks++;
    if (lk_hit !== h || lk_idx !== i || lk_pci_addr !== p) begin
      failures++;
      $display("FAIL %s addr=%h actual=%b/%0d/%h expected=%b/%0d/%h",
               req, a, lk_hit, lk_idx, lk_pci_addr, h, i, p);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int k = 0; k < 11; k++) rd_chk("R1", 8'h68 + 8'(4 * k), 32'h0);
    lk_chk("R1", 64'h0, 1'b0, 2'd0, 64'h0);

    // R2: round trip on every mapped offset
    for (int k = 0; k < 11; k++) wr(8'h68 + 8'(4 * k), 32'hA500_0000 + 32'(k) * 32'h0101_0102);
    for (int k = 0; k < 11; k++) rd_chk("R2", 8'h68 + 8'(4 * k), 32'hA500_0000 + 32'(k) * 32'h0101_0102);

    // R3: halves kept
    wr(8'h68, 32'h1234_5678);
    rd_chk("R3", 8'h6C, 32'hA500_0000 + 32'h0101_0102);
    wr(8'h78, 32'hCAFE_F00D);
    rd_chk("R3", 8'h74, 32'hA500_0000 + 3 * 32'h0101_0102);

    // Program the vector setup
    wr(8'h70, 32'h0); wr(8'h84, 32'h0); wr(8'h90, 32'h0);
    wr(8'h68, 32'h0000_0000); wr(8'h6C, 32'h1);
    wr(8'h74, 32'h8000_0000); wr(8'h78, 32'h0);
    wr(8'h70, 32'hFFF0_0001);
    wr(8'h7C, 32'h000F_8000); wr(8'h80, 32'h1);
    wr(8'h88, 32'h0000_0000); wr(8'h8C, 32'h2);
    wr(8'h84, 32'hFFFF_0001);

    // R5 and R7: vector table
    @(negedge clk);
    for (int v = 0; v < NV; v++)
      lk_chk((v == 2) ? "R7" : "R5", V_ADDR[v], V_HIT[v], V_IDX[v], V_PCI[v]);

    // R4: clear enable of window 0
    wr(8'h70, 32'hFFF0_0000);
    lk_chk("R4", 64'h1_0000_0000, 1'b0, 2'd0, 64'h0);
    lk_chk("R4", 64'h1_000F_8000, 1'b1, 2'd1, 64'h2_0000_0000);

    // R6: zero mask means 0xFFFFFFFF length
    wr(8'h84, 32'h0);
    wr(8'h68, 32'h10); wr(8'h6C, 32'h0);
    wr(8'h70, 32'h0000_0001);
    lk_chk("R6", 64'h10 + 64'hFFFF_FFFE, 1'b1, 2'd0, 64'h8000_0000 + 64'hFFFF_FFFE);
    lk_chk("R6", 64'h10 + 64'hFFFF_FFFF, 1'b0, 2'd0, 64'h0);

    // R8: size-only word never maps
    wr(8'h70, 32'h0);
    wr(8'h90, 32'hFFF0_0001);
    rd_chk("R8", 8'h90, 32'hFFF0_0001);
    lk_chk("R8", 64'h0, 1'b0, 2'd0, 64'h0);
    lk_chk("R8", 64'h1000, 1'b0, 2'd0, 64'h0);

    // R9: unmapped offsets
    wr(8'h94, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R9", 8'h94, 32'h0);
    rd_chk("R9", 8'h00, 32'h0);
    rd_chk("R9", 8'h68, 32'h10);
    rd_chk("R9", 8'h70, 32'h0);

    // R10: write and lookup in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h70; reg_wdata = 32'hFFF0_0001;
    lk_chk("R10", 64'h20, 1'b0, 2'd0, 64'h0);
    @(negedge clk);
    reg_wr = 1'b0;
    lk_chk("R10", 64'h20, 1'b1, 2'd0, 64'h8000_0010);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule